// File: doc/BRIEF.md
# Word/Byte Payload Packer

This block sits between 32-bit FIFOs and the byte port of a serial bus engine. For one transfer it takes a 12-bit byte length and a direction. In the transmit direction it pops words from a transmit FIFO and hands bytes to the engine one at a time, starting with the least significant byte of each word. In the receive direction it gathers bytes from the engine into words, filling them from the most significant byte down, and pushes each finished word into a receive FIFO.

A transfer ends in one of four ways. All bytes may be moved. The peripheral may end a read early. The controller may raise an abort. In transmit, the engine may report that the address was not acknowledged. In every case the block raises a one-cycle completion pulse together with the number of bytes that actually moved. Unused bytes of the last transmit word are dropped. The unfilled bytes of a short receive word are written as zero.

Top module: `pld_packer`

## Requirements
- R1: While reset is held and after it is released, `done`, `tx_byte_valid`, `txf_ready`, `rx_byte_ready` and `rxf_valid` are all low.
- R2: In transmit (`dir_rx`=0), each word leaves as bits 7:0, then 15:8, then 23:16, then 31:24. Words 0x78563412 and 0x000000FE with length 5 produce the bytes 12 34 56 78 FE.
- R3: In transmit, unused bytes of the final word are discarded. The next transfer begins with bits 7:0 of a newly popped word.
- R4: In receive (`dir_rx`=1), the 1st, 2nd, 3rd and 4th bytes of each group of four land in bits 31:24, 23:16, 15:8 and 7:0 of the pushed word.
- R5: A receive that ends before a word is full still pushes that word, with its unfilled low bytes set to zero.
- R6: In receive, `xfer_count` equals the number of bytes taken, including a byte accepted in the same cycle as `rx_end`. In transmit, it equals the full length on normal completion, and 0 when `tx_nack` ends the transfer.
- R7: A length of 0 raises `done` one cycle after `start`, with `xfer_count` = 0 and no FIFO pop or push.
- R8: `abort` ends the transfer, and `xfer_count` reports the bytes moved so far, including any byte handshaken in the abort cycle. In transmit, the rest of the current word is discarded.
- R9: In transmit, when the FIFO holds the next word and the byte sink is always ready, the first byte of that word is handshaken in the cycle right after the last byte of the previous word. While a byte waits for `tx_byte_ready`, its value holds.
- R10: `done` is a single-cycle pulse. In transmit, it is high in the cycle after the final byte handshake. A receive word held by a stalled FIFO stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| dir_rx | input | 1 | 0 = transmit, 1 = receive |
| xfer_len | input | 12 | Transfer length in bytes |
| abort | input | 1 | End the current transfer now |
| tx_nack | input | 1 | Address not acknowledged (transmit) |
| done | output | 1 | Transfer complete pulse |
| xfer_count | output | 12 | Bytes moved, valid with `done` |
| txf_valid | input | 1 | Transmit FIFO has a word |
| txf_data | input | 32 | Transmit FIFO head word |
| txf_ready | output | 1 | Pop the transmit FIFO |
| tx_byte_valid | output | 1 | Byte offered to the bus engine |
| tx_byte | output | 8 | Byte to transmit |
| tx_byte_ready | input | 1 | Bus engine takes the byte |
| rx_byte_valid | input | 1 | Byte from the bus engine |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Peripheral ended the read |
| rx_byte_ready | output | 1 | Block takes the byte |
| rxf_valid | output | 1 | Word offered to the receive FIFO |
| rxf_data | output | 32 | Packed receive word |
| rxf_ready | input | 1 | Receive FIFO accepts the word |

## Verification
In receive, a byte handshake and the end-of-data indication can fall in the same cycle. The bench provokes this by raising `rx_end` together with the last byte's valid. It then checks that the count includes that byte, and that the partial word holds the byte in its proper lane with zeros below. In transmit, a byte handshake can coincide with `abort` or `tx_nack`. The bench raises those while the sink is always ready. It then checks the reported count against the bytes it actually captured, and checks that the following transfer starts on a fresh word.

// File: rtl/pld_pkg.sv
package pld_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } pld_dir_e;
endpackage

// File: rtl/pld_tx_ser.sv
module pld_tx_ser
    import pld_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              abort,
    input  logic              nack,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              b_valid,
    output logic [BYTE_W-1:0] b_data,
    input  logic              b_ready,
    output logic              done,
    output logic [LEN_W-1:0]  count,
    output logic              busy
);
    localparam int BPW   = WORD_W / BYTE_W;
    localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;

    logic              active, have;
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  sent, total;
    logic              take, last_in_word, final_b, stop, pop;

    assign take         = b_valid & b_ready;
    assign last_in_word = (idx == IDX_W'(BPW - 1));
    assign final_b      = take && ((sent + LEN_W'(1)) == total);
    assign stop         = active & (abort | nack);
    assign in_ready     = active & ~stop & (~have | (take & last_in_word & ~final_b));
    assign pop          = in_valid & in_ready;
    assign b_valid      = active & have;
    assign b_data       = word[int'(idx)*BYTE_W +: BYTE_W];
    assign busy         = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            have   <= 1'b0;
            word   <= '0;
            idx    <= '0;
            sent   <= '0;
            total  <= '0;
            done   <= 1'b0;
            count  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                if (len == '0) begin
                    done  <= 1'b1;
                    count <= '0;
                end else begin
                    active <= 1'b1;
                    have   <= 1'b0;
                    idx    <= '0;
                    sent   <= '0;
                    total  <= len;
                end
            end else if (active) begin
                if (stop) begin
                    active <= 1'b0;
                    have   <= 1'b0;
                    done   <= 1'b1;
                    count  <= nack ? '0 : sent + LEN_W'(take);
                end else begin
                    if (take) begin
                        sent <= sent + LEN_W'(1);
                        idx  <= idx + IDX_W'(1);
                    end
                    if (final_b) begin
                        active <= 1'b0;
                        have   <= 1'b0;
                        done   <= 1'b1;
                        count  <= sent + LEN_W'(1);
                    end else if (pop) begin
                        word <= in_data;
                        have <= 1'b1;
                        idx  <= '0;
                    end else if (take && last_in_word) begin
                        have <= 1'b0;
                    end
                end
            end
        end
    end

    AST_TX_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready && !abort && !nack) |=> (b_valid && $stable(b_data))); // R9
    AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_TX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done && $past(active)) |-> (count <= total)); // R6
endmodule

// File: rtl/pld_rx_pack.sv
module pld_rx_pack
    import pld_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              abort,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_end,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              done,
    output logic [LEN_W-1:0]  count,
    output logic              busy
);
    localparam int BPW   = WORD_W / BYTE_W;
    localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;

    logic              active, flush;
    logic [WORD_W-1:0] acc, acc_n;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  got, got_n, total;
    logic              take, full_push, last_b, ending, partial, flush_go;

    assign in_ready  = active & (~out_valid | out_ready);
    assign take      = in_valid & in_ready;
    assign got_n     = got + LEN_W'(take);
    assign last_b    = take && (got_n == total);
    assign full_push = take && ((idx == IDX_W'(BPW - 1)) || last_b);
    assign ending    = active & (in_end | abort) & ~last_b;
    assign partial   = take ? ~full_push : (idx != '0);
    assign flush_go  = flush & (~out_valid | out_ready);
    assign busy      = active | flush;

    always_comb begin
        acc_n = (idx == '0) ? '0 : acc;
        if (take) begin
            acc_n[(BPW - 1 - int'(idx))*BYTE_W +: BYTE_W] = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            flush     <= 1'b0;
            acc       <= '0;
            idx       <= '0;
            got       <= '0;
            total     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            done      <= 1'b0;
            count     <= '0;
        end else begin
            done <= 1'b0;
            if (full_push || flush_go) begin
                out_valid <= 1'b1;
                out_data  <= flush ? acc : acc_n;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end

            if (flush_go) begin
                flush <= 1'b0;
                done  <= 1'b1;
            end

            if (start && !active && !flush) begin
                if (len == '0) begin
                    done  <= 1'b1;
                    count <= '0;
                end else begin
                    active <= 1'b1;
                    idx    <= '0;
                    got    <= '0;
                    total  <= len;
                end
            end else if (active) begin
                if (take) begin
                    got <= got_n;
                    if (full_push) begin
                        idx <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                        acc <= acc_n;
                    end
                end
                if (last_b) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    count  <= got_n;
                end else if (ending) begin
                    active <= 1'b0;
                    count  <= got_n;
                    if (partial) begin
                        flush <= 1'b1;
                    end else begin
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    AST_RX_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (count <= total)); // R6
endmodule

// File: rtl/pld_packer.sv
module pld_packer
    import pld_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_rx,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              abort,
    input  logic              tx_nack,
    output logic              done,
    output logic [LEN_W-1:0]  xfer_count,
    input  logic              txf_valid,
    input  logic [WORD_W-1:0] txf_data,
    output logic              txf_ready,
    output logic              tx_byte_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_byte_ready,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end,
    output logic              rx_byte_ready,
    output logic              rxf_valid,
    output logic [WORD_W-1:0] rxf_data,
    input  logic              rxf_ready
);
    logic             tx_busy, rx_busy, tx_done, rx_done, go;
    logic [LEN_W-1:0] tx_cnt, rx_cnt;
    pld_dir_e         dir;

    assign dir = pld_dir_e'(dir_rx);
    assign go  = start & ~tx_busy & ~rx_busy;

    pld_tx_ser #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .start(go && dir == DIR_TX), .len(xfer_len),
        .abort(abort), .nack(tx_nack),
        .in_valid(txf_valid), .in_data(txf_data), .in_ready(txf_ready),
        .b_valid(tx_byte_valid), .b_data(tx_byte), .b_ready(tx_byte_ready),
        .done(tx_done), .count(tx_cnt), .busy(tx_busy)
    );

    pld_rx_pack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .start(go && dir == DIR_RX), .len(xfer_len),
        .abort(abort), .in_valid(rx_byte_valid), .in_byte(rx_byte),
        .in_end(rx_end), .in_ready(rx_byte_ready),
        .out_valid(rxf_valid), .out_data(rxf_data), .out_ready(rxf_ready),
        .done(rx_done), .count(rx_cnt), .busy(rx_busy)
    );

    assign done       = tx_done | rx_done;
    assign xfer_count = tx_done ? tx_cnt : rx_cnt;

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_done, rx_done})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy && !rx_busy) |-> (!tx_byte_valid && !rx_byte_ready && !txf_ready)); // R1
endmodule

// File: tb/pld_packer_tb.sv
module pld_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, dir_rx = 1'b0, abort = 1'b0, tx_nack = 1'b0;
    logic [11:0] xfer_len = '0;
    logic        done;
    logic [11:0] xfer_count;
    logic        txf_valid, txf_ready;
    logic [31:0] txf_data;
    logic        tx_byte_valid, tx_byte_ready;
    logic [7:0]  tx_byte;
    logic        rx_byte_valid = 1'b0, rx_end = 1'b0, rx_byte_ready;
    logic [7:0]  rx_byte = '0;
    logic        rxf_valid, rxf_ready;
    logic [31:0] rxf_data;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic [31:0] tq [0:15];
    int tq_wr = 0, tq_rd = 0;
    logic [7:0]  cap  [0:255];
    int          hcyc [0:255];
    int ncap = 0;
    logic [31:0] wcap [0:63];
    int nw = 0;
    int ndone = 0, done_cyc = 0, dbl = 0;
    logic [11:0] dcnt = '0;
    logic prev_done = 1'b0;

    always #5 clk = ~clk;

    assign txf_valid     = (tq_rd != tq_wr);
    assign txf_data      = tq[tq_rd % 16];
    assign tx_byte_ready = 1'b1;
    assign rxf_ready     = 1'b1;

    pld_packer u_dut (
        .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx), .xfer_len(xfer_len),
        .abort(abort), .tx_nack(tx_nack), .done(done), .xfer_count(xfer_count),
        .txf_valid(txf_valid), .txf_data(txf_data), .txf_ready(txf_ready),
        .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_byte_ready(tx_byte_ready),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_end(rx_end),
        .rx_byte_ready(rx_byte_ready), .rxf_valid(rxf_valid), .rxf_data(rxf_data),
        .rxf_ready(rxf_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (txf_valid && txf_ready) tq_rd <= tq_rd + 1;
        if (tx_byte_valid && tx_byte_ready) begin
            cap[ncap % 256]  <= tx_byte;
            hcyc[ncap % 256] <= cyc;
            ncap <= ncap + 1;
        end
        if (rxf_valid && rxf_ready) begin
            wcap[nw % 64] <= rxf_data;
            nw <= nw + 1;
        end
        if (done) begin
            ndone <= ndone + 1;
            dcnt <= xfer_count;
            done_cyc <= cyc;
        end
        if (done && prev_done) dbl <= dbl + 1;
        prev_done <= done;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        tq[tq_wr % 16] = w;
        tq_wr++;
    endtask

    task automatic kick(input logic rx, input logic [11:0] len);
        @(negedge clk);
        dir_rx = rx; xfer_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0, input string req);
        int t = 0;
        while (ndone == d0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(ndone > d0, req, ndone, d0 + 1);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic with_end);
        @(negedge clk);
        rx_byte_valid = 1'b1; rx_byte = b; rx_end = with_end;
        while (!rx_byte_ready) @(negedge clk);
        @(negedge clk);
        rx_byte_valid = 1'b0; rx_end = 1'b0;
    endtask

    task automatic t_reset;
        chk(!done && !tx_byte_valid && !txf_ready && !rx_byte_ready && !rxf_valid,
            "R1 during reset", {27'd0, done, tx_byte_valid, txf_ready, rx_byte_ready, rxf_valid}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!done && !tx_byte_valid && !txf_ready && !rx_byte_ready && !rxf_valid,
            "R1 after reset", {27'd0, done, tx_byte_valid, txf_ready, rx_byte_ready, rxf_valid}, 0);
    endtask

    task automatic t_tx_order;
        logic [7:0] exp [0:4];
        int b0 = ncap, d0 = ndone;
        exp[0] = 8'h12; exp[1] = 8'h34; exp[2] = 8'h56; exp[3] = 8'h78; exp[4] = 8'hFE;
        push_word(32'h78563412); push_word(32'h000000FE); push_word(32'h11223344);
        kick(1'b0, 12'd5);
        wait_done(d0, "R2 tx done");
        chk(ncap - b0 == 5, "R2 byte count", ncap - b0, 5);
        for (int i = 0; i < 5; i++) chk(cap[b0 + i] == exp[i], "R2 byte order", cap[b0 + i], exp[i]);
        chk(dcnt == 12'd5, "R6 tx full count", dcnt, 5);
        chk(hcyc[b0 + 4] == hcyc[b0 + 3] + 1, "R9 no gap at word edge", hcyc[b0 + 4], hcyc[b0 + 3] + 1);
        chk(done_cyc == hcyc[b0 + 4] + 1, "R10 done timing", done_cyc, hcyc[b0 + 4] + 1);
        chk(dbl == 0, "R10 done single pulse", dbl, 0);
        b0 = ncap; d0 = ndone;
        kick(1'b0, 12'd1);
        wait_done(d0, "R3 tx done");
        chk(cap[b0] == 8'h44, "R3 fresh word after drop", cap[b0], 8'h44);
    endtask

    task automatic t_tx_nack;
        int b0 = ncap, d0 = ndone;
        push_word(32'hA1A2A3A4); push_word(32'hB1B2B3B4);
        kick(1'b0, 12'd8);
        while (ncap < b0 + 2) @(negedge clk);
        tx_nack = 1'b1;
        @(negedge clk);
        tx_nack = 1'b0;
        wait_done(d0, "R6 nack done");
        chk(dcnt == 12'd0, "R6 nack count zero", dcnt, 0);
        b0 = ncap; d0 = ndone;
        kick(1'b0, 12'd1);
        wait_done(d0, "R3 after nack");
        chk(cap[b0] == 8'hB4, "R3 next word after nack", cap[b0], 8'hB4);
    endtask

    task automatic t_tx_abort;
        int b0 = ncap, d0 = ndone;
        push_word(32'hC1C2C3C4); push_word(32'hD1D2D3D4); push_word(32'hE1E2E3E4);
        kick(1'b0, 12'd8);
        while (ncap < b0 + 5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_done(d0, "R8 tx abort done");
        chk(dcnt == 12'(ncap - b0), "R8 tx abort count", dcnt, ncap - b0);
        chk(ncap - b0 < 8, "R8 tx abort ended early", ncap - b0, 7);
        b0 = ncap; d0 = ndone;
        kick(1'b0, 12'd1);
        wait_done(d0, "R8 after abort");
        chk(cap[b0] == 8'hE4, "R8 rest of word discarded", cap[b0], 8'hE4);
    endtask

    task automatic t_zero;
        int r0 = tq_rd, w0 = nw;
        push_word(32'h55555555);
        for (int d = 0; d < 2; d++) begin
            kick(d[0], 12'd0);
            chk(done && xfer_count == 0, "R7 zero length done", {20'd0, xfer_count}, 0);
            @(negedge clk);
            chk(!done, "R7 done drops", done, 0);
        end
        chk(tq_rd == r0 && nw == w0, "R7 no fifo traffic", tq_rd - r0 + nw - w0, 0);
        tq_wr = tq_rd;
    endtask

    task automatic t_rx_full;
        int w0 = nw, d0 = ndone;
        kick(1'b1, 12'd6);
        for (int i = 0; i < 6; i++) send_rx(8'(i), 1'b0);
        wait_done(d0, "R4 rx done");
        @(negedge clk);
        chk(nw - w0 == 2, "R4 word count", nw - w0, 2);
        chk(wcap[w0] == 32'h00010203, "R4 msb first", wcap[w0], 32'h00010203);
        chk(wcap[w0 + 1] == 32'h04050000, "R5 partial zero fill", wcap[w0 + 1], 32'h04050000);
        chk(dcnt == 12'd6, "R6 rx full count", dcnt, 6);
    endtask

    task automatic t_rx_early;
        int w0 = nw, d0 = ndone;
        kick(1'b1, 12'd10);
        send_rx(8'hAA, 1'b0); send_rx(8'hBB, 1'b0); send_rx(8'hCC, 1'b0);
        send_rx(8'hDD, 1'b0); send_rx(8'hEE, 1'b0);
        @(negedge clk); rx_end = 1'b1;
        @(negedge clk); rx_end = 1'b0;
        wait_done(d0, "R5 rx early done");
        @(negedge clk);
        chk(dcnt == 12'd5, "R6 rx early count", dcnt, 5);
        chk(nw - w0 == 2, "R5 word count", nw - w0, 2);
        chk(wcap[w0 + 1] == 32'hEE000000, "R5 early partial", wcap[w0 + 1], 32'hEE000000);
    endtask

    task automatic t_rx_same_cycle;
        int w0 = nw, d0 = ndone;
        kick(1'b1, 12'd10);
        send_rx(8'h11, 1'b0); send_rx(8'h22, 1'b0); send_rx(8'h33, 1'b1);
        wait_done(d0, "R6 same-cycle done");
        @(negedge clk);
        chk(dcnt == 12'd3, "R6 byte with end counted", dcnt, 3);
        chk(wcap[w0] == 32'h11223300, "R5 same-cycle partial", wcap[w0], 32'h11223300);
    endtask

    task automatic t_rx_abort;
        int w0 = nw, d0 = ndone;
        kick(1'b1, 12'd12);
        for (int i = 0; i < 6; i++) send_rx(8'hF0 + 8'(i), 1'b0);
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        wait_done(d0, "R8 rx abort done");
        @(negedge clk);
        chk(dcnt == 12'd6, "R8 rx abort count", dcnt, 6);
        chk(wcap[w0 + 1] == 32'hF4F50000, "R8 rx abort partial", wcap[w0 + 1], 32'hF4F50000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_nack();
        t_tx_abort();
        t_zero();
        t_rx_full();
        t_rx_early();
        t_rx_same_cycle();
        t_rx_abort();
        chk(dbl == 0, "R10 done never two cycles", dbl, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule